// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

This block is a first-in first-out buffer of 64 words, each 4 bits wide. It keeps its words in a two-port register array and tracks them with separate write and read pointers, so a producer and a consumer can work at the same time. The producer raises a write strobe to hand over a word and lowers it to commit the word. The consumer raises a read strobe to take the presented word and lowers it to move on. A ready flag on each side shows when that side may act.

Both strobes and the active-low clear are level signals that come from outside the clock domain. Each one passes through a two-flop synchronizer, and its edges are found by comparing it with its value one cycle earlier. A word committed into an empty buffer reaches the output register one cycle after the write pointer moves. A slot freed in a full buffer re-opens the write side one cycle after the read pointer moves. The output enable is active low. While it is high, it forces the data outputs to zero.

Top module: `strobe_fifo`

## Requirements
- R1: The buffer holds up to 64 words of 4 bits. Words leave in the order they were committed. A write and a read may be committed on the same clock edge, and the buffer never holds more than 64 words.
- R2: While clear_n is low, and once it is released, wr_ready is 1, rd_valid is 0 and rd_data is 4'h0. Asserting clear_n at any time discards every stored word.
- R3: When a rising edge of wr_strobe is seen while wr_ready is 1, wr_data is stored into the current write slot and wr_ready goes to 0 while the strobe stays high.
- R4: On the following falling edge of wr_strobe, the write pointer advances. wr_ready then returns to 1, unless the buffer now holds 64 words, in which case it stays 0.
- R5: A wr_strobe pulse that starts while wr_ready is 0 stores nothing and does not move the write pointer.
- R6: When a rising edge of rd_strobe is seen while rd_valid is 1, rd_valid goes to 0 and rd_data keeps the current word until the strobe falls.
- R7: On the falling edge of rd_strobe, the read pointer advances. If another word is stored, it appears on rd_data and rd_valid returns to 1. Otherwise rd_valid stays 0.
- R8: When the buffer runs empty, rd_data keeps the last word read. A rd_strobe pulse while rd_valid is 0 changes neither rd_valid nor rd_data.
- R9: A strobe change takes effect on the third rising clock edge after it is driven. Lowering wr_strobe into an empty buffer raises rd_valid, with the word on rd_data, on the fourth rising edge. Lowering rd_strobe on a full buffer raises wr_ready on the fourth rising edge.
- R10: While oe_n is 1, rd_data reads 4'h0. While oe_n is 0, rd_data shows the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear_n | input | 1 | Active-low clear; asserts asynchronously and is released through a synchronizer |
| wr_strobe | input | 1 | Write strobe; the rising edge stores a word, the falling edge commits it |
| wr_data | input | 4 | Word to store; held stable while wr_strobe is high |
| wr_ready | output | 1 | High when a new write may begin |
| rd_strobe | input | 1 | Read strobe; the rising edge takes the word, the falling edge moves to the next |
| rd_valid | output | 1 | High when rd_data holds an unread word |
| oe_n | input | 1 | Active-low output enable |
| rd_data | output | 4 | Output word register, gated by oe_n |

## Verification
A write commit and a read commit can land on the same clock edge. Both pointers then move together, and the write side must judge fullness against the read pointer before it moves. The bench provokes this by raising and lowering both strobes on the same clock with 63 words stored, which keeps wr_ready high. It repeats the exchange more than a full buffer's worth of times, so both pointers wrap. After each exchange it checks the word that came out against an arithmetic queue model, and it checks that both ready flags return high. At the full boundary, a read commit must re-open the write side exactly one cycle after the read pointer moves, and the bench times this to the clock edge.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

  // number of stored words given two pointers carrying one wrap bit above the address
  function automatic logic [31:0] occupancy(input logic [31:0] wp,
                                            input logic [31:0] rp,
                                            input int unsigned pw);
    return (wp - rp) & ((32'd1 << pw) - 32'd1);
  endfunction

  // single-cycle level-change detectors
  function automatic logic rose_now(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic fell_now(input logic cur, input logic prev);
    return ~cur & prev;
  endfunction

endpackage

// File: rtl/sf_sync.sv
module sf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sf_rst_sync.sv
module sf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clear_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) chain <= '0;
    else          chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/sf_mem.sv
module sf_mem #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/sf_wr_ctrl.sv
module sf_wr_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        si_s,
  input  logic [AW:0] rd_ptr,
  output logic [AW:0] wr_ptr,
  output logic        we,
  output logic        in_ready,
  output logic        si_rise,
  output logic        si_fall,
  output logic        wr_pend,
  output logic        full
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW:0] ONE   = 1;

  logic si_q;
  logic full_after;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) si_q <= 1'b0;
    else        si_q <= si_s;
  end

  assign si_rise    = rose_now(si_s, si_q);
  assign si_fall    = fell_now(si_s, si_q);
  assign full       = occupancy(32'(wr_ptr), 32'(rd_ptr), PW) == 32'(DEPTH);
  assign full_after = occupancy(32'(wr_ptr + ONE), 32'(rd_ptr), PW) == 32'(DEPTH);
  assign we         = si_rise & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      in_ready <= 1'b1;
      wr_pend  <= 1'b0;
    end else if (we) begin
      in_ready <= 1'b0;
      wr_pend  <= 1'b1;
    end else if (si_fall && wr_pend) begin
      wr_ptr   <= wr_ptr + ONE;
      wr_pend  <= 1'b0;
      in_ready <= ~full_after;
    end else if (!wr_pend && !in_ready && !full) begin
      in_ready <= 1'b1;
    end
  end
endmodule

// File: rtl/sf_rd_ctrl.sv
module sf_rd_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          so_s,
  input  logic [AW:0]   wr_ptr,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW:0]   rd_ptr,
  output logic          out_ready,
  output logic [DW-1:0] dout_q,
  output logic          so_rise,
  output logic          so_fall,
  output logic          rd_pend,
  output logic          empty
);
  localparam int unsigned PW  = AW + 1;
  localparam logic [AW:0] ONE = 1;

  logic so_q;
  logic take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) so_q <= 1'b0;
    else        so_q <= so_s;
  end

  assign so_rise = rose_now(so_s, so_q);
  assign so_fall = fell_now(so_s, so_q);
  assign empty   = occupancy(32'(wr_ptr), 32'(rd_ptr), PW) == 32'd0;
  assign take    = so_rise & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      out_ready <= 1'b0;
      rd_pend   <= 1'b0;
      dout_q    <= '0;
    end else if (take) begin
      out_ready <= 1'b0;
      rd_pend   <= 1'b1;
    end else if (so_fall && rd_pend) begin
      rd_ptr    <= rd_ptr + ONE;
      rd_pend   <= 1'b0;
    end else if (!rd_pend && !out_ready && !empty) begin
      dout_q    <= mem_rdata;
      out_ready <= 1'b1;
    end
  end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          clear_n,
  input  logic          wr_strobe,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_strobe,
  output logic          rd_valid,
  input  logic          oe_n,
  output logic [DW-1:0] rd_data
);
  logic          rst_n_i;
  logic [1:0]    strobes_s;
  logic          si_s, so_s;
  logic [AW:0]   wr_ptr, rd_ptr;
  logic          we, si_rise, si_fall, wr_pend, full;
  logic          so_rise, so_fall, rd_pend, empty;
  logic [DW-1:0] mem_rdata, dout_q;

  sf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .clear_n(clear_n), .rst_n(rst_n_i)
  );

  sf_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .d({rd_strobe, wr_strobe}), .q(strobes_s)
  );
  assign si_s = strobes_s[0];
  assign so_s = strobes_s[1];

  sf_wr_ctrl #(.AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n_i), .si_s(si_s), .rd_ptr(rd_ptr),
    .wr_ptr(wr_ptr), .we(we), .in_ready(wr_ready), .si_rise(si_rise),
    .si_fall(si_fall), .wr_pend(wr_pend), .full(full)
  );

  sf_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(we), .waddr(wr_ptr[AW-1:0]), .wdata(wr_data),
    .raddr(rd_ptr[AW-1:0]), .rdata(mem_rdata)
  );

  sf_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n_i), .so_s(so_s), .wr_ptr(wr_ptr),
    .mem_rdata(mem_rdata), .rd_ptr(rd_ptr), .out_ready(rd_valid),
    .dout_q(dout_q), .so_rise(so_rise), .so_fall(so_fall),
    .rd_pend(rd_pend), .empty(empty)
  );

  assign rd_data = oe_n ? '0 : dout_q;
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk
  import strobe_fifo_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          si_rise,
  input logic          si_fall,
  input logic          wr_pend,
  input logic          in_ready,
  input logic [AW:0]   wr_ptr,
  input logic [AW:0]   rd_ptr,
  input logic          so_rise,
  input logic          so_fall,
  input logic          rd_pend,
  input logic          out_ready,
  input logic [DW-1:0] dout_q,
  input logic          empty
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW:0] ONE   = 1;

  logic [31:0] level;
  assign level = occupancy(32'(wr_ptr), 32'(rd_ptr), PW);

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= 32'(DEPTH));

  assert_reset_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !out_ready && dout_q == '0));

  assert_capture_drops_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (si_rise && in_ready) |=> (!in_ready && wr_pend));

  assert_commit_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (si_fall && wr_pend) |=> (wr_ptr == $past(wr_ptr) + ONE));

  assert_blocked_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (si_rise && !in_ready) |=> ($stable(wr_ptr) && !wr_pend));

  assert_take_holds_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (so_rise && out_ready) |=> (!out_ready && $stable(dout_q)));

  assert_read_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (so_fall && rd_pend) |=> (rd_ptr == $past(rd_ptr) + ONE && !out_ready));

  assert_empty_keeps_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !out_ready && !rd_pend) |=> $stable(dout_q));

  assert_fall_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !out_ready && !rd_pend) |=> out_ready);

  assert_reopen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_pend && !in_ready && level < 32'(DEPTH)) |=> in_ready);
endmodule

bind strobe_fifo strobe_fifo_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .si_rise(si_rise), .si_fall(si_fall),
  .wr_pend(wr_pend), .in_ready(wr_ready), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .so_rise(so_rise), .so_fall(so_fall), .rd_pend(rd_pend),
  .out_ready(rd_valid), .dout_q(dout_q), .empty(empty)
);

// File: tb/strobe_fifo_test.sv
module strobe_fifo_test;
  logic       clk = 1'b0;
  logic       clear_n = 1'b0;
  logic       wr_strobe = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic       rd_strobe = 1'b0;
  logic       oe_n = 1'b0;
  logic       wr_ready, rd_valid;
  logic [3:0] rd_data;

  int vectors = 0;
  int miscompares = 0;

  logic [3:0] model [0:511];
  int head = 0;
  int tail = 0;

  strobe_fifo uut (
    .clk(clk), .clear_n(clear_n), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_strobe(rd_strobe), .rd_valid(rd_valid),
    .oe_n(oe_n), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(input int i);
    return 4'((i * 5 + 2) % 16);
  endfunction

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [3:0] v, input logic accepted);
    @(negedge clk);
    wr_data = v;
    wr_strobe = 1'b1;
    waitn(4);
    chk("R3/R5 wr_ready mid-pulse", 32'(wr_ready), 32'd0);
    wr_strobe = 1'b0;
    waitn(5);
    if (accepted) begin
      model[tail] = v;
      tail++;
    end
  endtask

  task automatic pop_check(input string req);
    chk({req, " rd_valid before read"}, 32'(rd_valid), 32'd1);
    chk({req, " word order"}, 32'(rd_data), 32'(model[head]));
    @(negedge clk);
    rd_strobe = 1'b1;
    waitn(4);
    chk("R6 rd_valid low mid-pulse", 32'(rd_valid), 32'd0);
    chk("R6 word held mid-pulse", 32'(rd_data), 32'(model[head]));
    rd_strobe = 1'b0;
    waitn(5);
    head++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R2: reset state during and after clear
    waitn(3);
    chk("R2 wr_ready in clear", 32'(wr_ready), 32'd1);
    chk("R2 rd_valid in clear", 32'(rd_valid), 32'd0);
    chk("R2 rd_data in clear", 32'(rd_data), 32'd0);
    clear_n = 1'b1;
    waitn(4);
    chk("R2 wr_ready after release", 32'(wr_ready), 32'd1);
    chk("R2 rd_valid after release", 32'(rd_valid), 32'd0);
    chk("R2 rd_data after release", 32'(rd_data), 32'd0);

    // R9: fall-through timing into an empty buffer
    @(negedge clk);
    wr_data = 4'h5;
    wr_strobe = 1'b1;
    waitn(4);
    chk("R3 wr_ready drops on capture", 32'(wr_ready), 32'd0);
    wr_strobe = 1'b0;
    waitn(3);
    chk("R9 rd_valid before fourth edge", 32'(rd_valid), 32'd0);
    waitn(1);
    chk("R9 rd_valid on fourth edge", 32'(rd_valid), 32'd1);
    chk("R9 word fell through", 32'(rd_data), 32'h5);
    chk("R4 wr_ready back high", 32'(wr_ready), 32'd1);
    model[tail] = 4'h5;
    tail++;
    pop_check("R7 single word");
    chk("R7 rd_valid low when empty", 32'(rd_valid), 32'd0);
    chk("R8 last word kept", 32'(rd_data), 32'h5);

    // R8: read pulse on empty buffer is ignored
    @(negedge clk);
    rd_strobe = 1'b1;
    waitn(4);
    rd_strobe = 1'b0;
    waitn(6);
    chk("R8 rd_valid after empty read", 32'(rd_valid), 32'd0);
    chk("R8 rd_data after empty read", 32'(rd_data), 32'h5);

    // R4: fill to 64, wr_ready low only after the last
    for (int i = 0; i < 64; i++) begin
      push(pat(i), 1'b1);
      chk("R4 wr_ready after commit", 32'(wr_ready), (i < 63) ? 32'd1 : 32'd0);
    end

    // R5: write attempt on a full buffer is ignored
    push(4'hF, 1'b0);
    chk("R5 wr_ready stays low when full", 32'(wr_ready), 32'd0);

    // R9: read from full buffer, wr_ready re-opens on fourth edge
    chk("R1 head word", 32'(rd_data), 32'(model[head]));
    @(negedge clk);
    rd_strobe = 1'b1;
    waitn(4);
    rd_strobe = 1'b0;
    head++;
    waitn(3);
    chk("R9 wr_ready before fourth edge", 32'(wr_ready), 32'd0);
    waitn(1);
    chk("R9 wr_ready on fourth edge", 32'(wr_ready), 32'd1);
    chk("R7 next word presented", 32'(rd_valid), 32'd1);
    chk("R7 next word value", 32'(rd_data), 32'(model[head]));

    // R1: concurrent write and read commits with 63 words stored
    for (int k = 0; k < 70; k++) begin
      logic [3:0] v;
      v = 4'((k * 3 + 9) % 16);
      chk("R1 word out before exchange", 32'(rd_data), 32'(model[head]));
      @(negedge clk);
      wr_data = v;
      wr_strobe = 1'b1;
      rd_strobe = 1'b1;
      waitn(4);
      wr_strobe = 1'b0;
      rd_strobe = 1'b0;
      waitn(5);
      model[tail] = v;
      tail++;
      head++;
      chk("R1 wr_ready after exchange", 32'(wr_ready), 32'd1);
      chk("R1 rd_valid after exchange", 32'(rd_valid), 32'd1);
    end

    // R10: output enable gating
    oe_n = 1'b1;
    waitn(1);
    chk("R10 rd_data gated", 32'(rd_data), 32'd0);
    oe_n = 1'b0;
    waitn(1);
    chk("R10 rd_data enabled", 32'(rd_data), 32'(model[head]));

    // R1/R7/R8: drain everything in order
    while (head < tail) pop_check("R1 drain");
    chk("R7 empty after drain", 32'(rd_valid), 32'd0);
    chk("R8 last word after drain", 32'(rd_data), 32'(model[tail-1]));

    // R2: clear in the middle of traffic
    push(4'hA, 1'b1);
    push(4'hB, 1'b1);
    @(negedge clk);
    clear_n = 1'b0;
    waitn(1);
    chk("R2 rd_valid in mid clear", 32'(rd_valid), 32'd0);
    chk("R2 rd_data in mid clear", 32'(rd_data), 32'd0);
    clear_n = 1'b1;
    waitn(8);
    chk("R2 empty after clear", 32'(rd_valid), 32'd0);
    chk("R2 wr_ready after clear", 32'(wr_ready), 32'd1);
    head = tail;
    push(4'h3, 1'b1);
    chk("R2 first word after clear", 32'(rd_data), 32'h3);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule